// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator

This block compares two 32-bit single-precision binary floating-point operands and stores the result of one chosen test in a one-bit condition flag. A 2-bit operation code selects the test: equal, less-than or less-or-equal. The test is evaluated combinationally. The flag register captures the result only on a cycle where the compare strobe is high, and then holds it so that a later branch can test it.

Each operand is sorted into one of five classes: zero, denormal, normal, infinity or NaN. The class is reported on a one-hot output for each operand. The ordering logic follows the special-operand rules of the format rather than a plain integer compare:

- NaN fails every test.
- The two signed zeros are equal.
- Denormals order correctly against each other and against normals.
- Negative values order in the reverse sense of their magnitudes.

Top module: `fp_compare_unit`

## Requirements
- R1: Each class output is one-hot and updates combinationally from its operand. The bit positions are: bit 0 is zero (exponent 0, fraction 0); bit 1 is denormal (exponent 0, fraction nonzero); bit 2 is normal (exponent 1 to 254); bit 3 is infinity (exponent 255, fraction 0); bit 4 is NaN (exponent 255, fraction nonzero).
- R2: When either operand is NaN, a strobed equal, less-than or less-or-equal test writes 0 to the flag.
- R3: +0 and -0 compare as equal in either order, and neither is less than the other.
- R4: When the signs differ and the operands are not both zero, the negative operand is the lesser one.
- R5: When both operands are non-negative, they order by their magnitude field, meaning the {exponent, fraction} bits taken as unsigned. This holds across denormals, normals and infinity.
- R6: When both operands are negative, they order in the reverse sense of their magnitude fields.
- R7: The flag changes only on a rising clock edge where strobe_i is high. On all other edges it holds its value.
- R8: Operation codes are 2'b00 for equal (a == b), 2'b01 for less-than (a < b) and 2'b10 for less-or-equal (a <= b). Code 2'b11 is reserved, and a strobe carrying it leaves the flag unchanged.
- R9: While rst_ni is low, the flag is 0.
- R10: A strobed result appears on flag_o after the rising edge that samples the strobe, with one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| opa_i | input | 32 | Operand a, single precision |
| opb_i | input | 32 | Operand b, single precision |
| op_i | input | 2 | Test select: 00 equal, 01 less-than, 10 less-or-equal, 11 reserved |
| strobe_i | input | 1 | Capture the selected test into the flag |
| flag_o | output | 1 | Registered condition flag |
| a_class_o | output | 5 | One-hot class of operand a |
| b_class_o | output | 5 | One-hot class of operand b |

## Verification
The class decode and the flag update fall in the same cycle. The class outputs follow the operands that are present right now, while the flag still shows the result of the previous strobe. The bench changes operands on every cycle, including cycles without a strobe and cycles with the reserved code. In each cycle it compares both the live class bits and the held flag against a behavioural model. That model orders operands through a signed integer key and lets the flag change only on strobed, non-reserved edges.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAG_W  = WORD_W - 1;
  localparam int CLS_W  = 5;

  localparam int CLS_ZERO = 0;
  localparam int CLS_DEN  = 1;
  localparam int CLS_NORM = 2;
  localparam int CLS_INF  = 3;
  localparam int CLS_NAN  = 4;

  typedef enum logic [1:0] {
    CMP_EQ  = 2'b00,
    CMP_LT  = 2'b01,
    CMP_LE  = 2'b10,
    CMP_RSV = 2'b11
  } cmp_op_e;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify
  import fpcmp_pkg::*;
#(
  parameter int EW = EXP_W,
  parameter int FW = FRAC_W
) (
  input  logic [EW+FW:0]     word_i,
  output logic               sign_o,
  output logic [EW+FW-1:0]   mag_o,
  output logic [CLS_W-1:0]   class_o
);
  localparam logic [EW-1:0] EXP_ONES = '1;

  logic [EW-1:0] exp_w;
  logic [FW-1:0] frac_w;
  logic          exp_min, exp_max, frac_nz;

  assign sign_o  = word_i[EW+FW];
  assign mag_o   = word_i[EW+FW-1:0];
  assign exp_w   = word_i[EW+FW-1:FW];
  assign frac_w  = word_i[FW-1:0];
  assign exp_min = (exp_w == '0);
  assign exp_max = (exp_w == EXP_ONES);
  assign frac_nz = |frac_w;

  always_comb begin
    class_o           = '0;
    class_o[CLS_ZERO] = exp_min & ~frac_nz;
    class_o[CLS_DEN]  = exp_min &  frac_nz;
    class_o[CLS_NORM] = ~exp_min & ~exp_max;
    class_o[CLS_INF]  = exp_max & ~frac_nz;
    class_o[CLS_NAN]  = exp_max &  frac_nz;
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order #(
  parameter int MW = fpcmp_pkg::MAG_W
) (
  input  logic          sign_a_i,
  input  logic          sign_b_i,
  input  logic [MW-1:0] mag_a_i,
  input  logic [MW-1:0] mag_b_i,
  input  logic          any_nan_i,
  input  logic          both_zero_i,
  output logic          eq_o,
  output logic          lt_o
);
  logic mag_lt, mag_gt, mag_eq, same_sign;

  assign mag_lt    = mag_a_i < mag_b_i;
  assign mag_gt    = mag_a_i > mag_b_i;
  assign mag_eq    = mag_a_i == mag_b_i;
  assign same_sign = sign_a_i == sign_b_i;

  always_comb begin
    eq_o = 1'b0;
    lt_o = 1'b0;
    if (!any_nan_i) begin
      if (both_zero_i) begin
        eq_o = 1'b1;
      end else if (!same_sign) begin
        lt_o = sign_a_i;
      end else begin
        eq_o = mag_eq;
        lt_o = sign_a_i ? mag_gt : mag_lt;  // negatives reverse the sense
      end
    end
  end
endmodule

// File: rtl/fp_compare_unit.sv
module fp_compare_unit
  import fpcmp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] opa_i,
  input  logic [WORD_W-1:0] opb_i,
  input  logic [1:0]        op_i,
  input  logic              strobe_i,
  output logic              flag_o,
  output logic [CLS_W-1:0]  a_class_o,
  output logic [CLS_W-1:0]  b_class_o
);
  localparam int N_OPND = 2;

  logic [WORD_W-1:0] word_w  [N_OPND];
  logic              sign_w  [N_OPND];
  logic [MAG_W-1:0]  mag_w   [N_OPND];
  logic [CLS_W-1:0]  class_w [N_OPND];
  logic              eq_w, lt_w, res_w, res_vld;
  cmp_op_e           op_w;

  assign word_w[0] = opa_i;
  assign word_w[1] = opb_i;

  for (genvar g = 0; g < N_OPND; g++) begin : g_cls
    fpcmp_classify #(.EW(EXP_W), .FW(FRAC_W)) u_cls (
      .word_i  (word_w[g]),
      .sign_o  (sign_w[g]),
      .mag_o   (mag_w[g]),
      .class_o (class_w[g])
    );
  end

  fpcmp_order #(.MW(MAG_W)) u_ord (
    .sign_a_i    (sign_w[0]),
    .sign_b_i    (sign_w[1]),
    .mag_a_i     (mag_w[0]),
    .mag_b_i     (mag_w[1]),
    .any_nan_i   (class_w[0][CLS_NAN] | class_w[1][CLS_NAN]),
    .both_zero_i (class_w[0][CLS_ZERO] & class_w[1][CLS_ZERO]),
    .eq_o        (eq_w),
    .lt_o        (lt_w)
  );

  assign op_w = cmp_op_e'(op_i);

  always_comb begin
    res_vld = 1'b1;
    unique case (op_w)
      CMP_EQ:  res_w = eq_w;
      CMP_LT:  res_w = lt_w;
      CMP_LE:  res_w = lt_w | eq_w;
      default: begin res_w = 1'b0; res_vld = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_o <= 1'b0;
    else if (strobe_i && res_vld) flag_o <= res_w;
  end

  assign a_class_o = class_w[0];
  assign b_class_o = class_w[1];
endmodule

// File: rtl/fpcmp_check.sv
module fpcmp_check
  import fpcmp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] opa_i,
  input logic [WORD_W-1:0] opb_i,
  input logic [1:0]        op_i,
  input logic              strobe_i,
  input logic              flag_i,
  input logic [CLS_W-1:0]  a_cls_i,
  input logic [CLS_W-1:0]  b_cls_i
);
  logic any_nan, both_zero, real_op;
  assign any_nan   = a_cls_i[CLS_NAN] | b_cls_i[CLS_NAN];
  assign both_zero = a_cls_i[CLS_ZERO] & b_cls_i[CLS_ZERO];
  assign real_op   = op_i != 2'b11;

  a_r1_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(a_cls_i) == 1 && $countones(b_cls_i) == 1);

  a_r2_nan_false: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && real_op && any_nan |=> !flag_i);

  a_r3_zero_eq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == 2'b00 && both_zero |=> flag_i);

  a_r4_neg_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && op_i == 2'b01 && opa_i[WORD_W-1] && !opb_i[WORD_W-1]
      && !any_nan && !both_zero |=> flag_i);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(flag_i));

  a_r8_reserved: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i && !real_op |=> $stable(flag_i));

  always_comb begin
    if (!rst_ni) a_r9_reset: assert (!flag_i);
  end
endmodule

bind fp_compare_unit fpcmp_check u_fpcmp_check (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .op_i     (op_i),
  .strobe_i (strobe_i),
  .flag_i   (flag_o),
  .a_cls_i  (a_class_o),
  .b_cls_i  (b_class_o)
);

// File: tb/fp_compare_unit_tb.sv
module fp_compare_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opa = '0, opb = '0;
  logic [1:0]  op = 2'b00;
  logic        stb = 1'b0;
  logic        flag;
  logic [4:0]  a_cls, b_cls;

  int    n_chk = 0, n_fail = 0;
  bit    ref_flag = 1'b0;
  string cur_tag = "R9", flag_tag = "R9";

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_compare_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .opa_i(opa), .opb_i(opb), .op_i(op),
    .strobe_i(stb), .flag_o(flag), .a_class_o(a_cls), .b_class_o(b_cls)
  );

  function automatic bit is_nan(input logic [31:0] w);
    return w[30:23] == 8'hFF && w[22:0] != 0;
  endfunction

  // ordering key: signed magnitude as an integer; both zeros map to 0
  function automatic longint key(input logic [31:0] w);
    longint m = longint'(w[30:0]);
    return w[31] ? -m : m;
  endfunction

  function automatic logic [4:0] exp_cls(input logic [31:0] w);
    int e = int'(w[30:23]);
    if (e == 255) return (w[22:0] != 0) ? 5'b10000 : 5'b01000;
    if (e != 0)   return 5'b00100;
    return (w[22:0] != 0) ? 5'b00010 : 5'b00001;
  endfunction

  function automatic bit exp_res(input logic [31:0] a, b, input logic [1:0] o);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    case (o)
      2'b00:   return key(a) == key(b);
      2'b01:   return key(a) <  key(b);
      default: return key(a) <= key(b);
    endcase
  endfunction

  // reference flag: R7, R8, R9, R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_flag <= 1'b0;
    else if (stb && op != 2'b11) begin
      ref_flag <= exp_res(opa, opb, op);
      flag_tag <= cur_tag;
    end else if (stb) flag_tag <= "R8";
    else flag_tag <= "R7";
  end

  task automatic check(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check("R1", 32'(a_cls), 32'(exp_cls(opa)));
      check("R1", 32'(b_cls), 32'(exp_cls(opb)));
      check(flag_tag, 32'(flag), 32'(ref_flag));
    end
  end

  task automatic apply(input logic [31:0] a, b, input logic [1:0] o,
                       input logic s, input string tag);
    @(posedge clk);
    #(CLK_PERIOD/4);
    opa = a; opb = b; op = o; stb = s; cur_tag = tag;
  endtask

  localparam logic [31:0] P1 = 32'h3F80_0000, P2 = 32'h4000_0000;
  localparam logic [31:0] N1 = 32'hBF80_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000;
  localparam logic [31:0] PINF = 32'h7F80_0000, NINF = 32'hFF80_0000;
  localparam logic [31:0] QNAN = 32'h7FC0_0000, NNAN = 32'hFF80_0001;
  localparam logic [31:0] MAXF = 32'h7F7F_FFFF, MINN = 32'h0080_0000;
  localparam logic [31:0] MAXD = 32'h007F_FFFF, D1 = 32'h1, D2 = 32'h2;

  initial begin
    #(CLK_PERIOD*2);
    check("R9", 32'(flag), 32'h0);
    #(CLK_PERIOD/2) rst_n = 1'b1;
    // R2: set flag high, then NaN must clear it
    apply(P1, P1, 2'b00, 1, "R2");
    apply(QNAN, P1, 2'b00, 1, "R2");
    apply(P1, P1, 2'b10, 1, "R2");
    apply(P1, NNAN, 2'b10, 1, "R2");
    apply(P1, P1, 2'b00, 1, "R2");
    apply(NINF, QNAN, 2'b01, 1, "R2");
    apply(QNAN, QNAN, 2'b00, 1, "R2");
    // R3: signed zeros
    apply(PZ, NZ, 2'b00, 1, "R3");
    apply(NZ, PZ, 2'b01, 1, "R3");
    apply(PZ, NZ, 2'b10, 1, "R3");
    apply(PZ, NZ, 2'b01, 1, "R3");
    // R4: mixed signs
    apply(N1, P1, 2'b01, 1, "R4");
    apply(P1, N1, 2'b01, 1, "R4");
    apply(32'h8000_0001, PZ, 2'b01, 1, "R4");
    apply(PZ, 32'h8000_0001, 2'b10, 1, "R4");
    // R5: non-negative ordering incl. denormals
    apply(D1, D2, 2'b01, 1, "R5");
    apply(MAXD, MINN, 2'b01, 1, "R5");
    apply(MAXF, PINF, 2'b01, 1, "R5");
    apply(P2, P1, 2'b10, 1, "R5");
    apply(P1, P1, 2'b10, 1, "R5");
    // R6: negatives reversed
    apply(N2, N1, 2'b01, 1, "R6");
    apply(N1, N2, 2'b01, 1, "R6");
    apply(NINF, 32'hFF7F_FFFF, 2'b01, 1, "R6");
    apply(32'h8000_0002, 32'h8000_0001, 2'b10, 1, "R6");
    // R7: no strobe, result would differ
    apply(P1, P2, 2'b00, 1, "R7");
    apply(P1, P1, 2'b00, 0, "R7");
    apply(P1, P1, 2'b10, 0, "R7");
    // R8: reserved code with strobe
    apply(P1, P1, 2'b00, 1, "R8");
    apply(P1, P2, 2'b11, 1, "R8");
    apply(P2, P1, 2'b11, 1, "R8");
    // R10 and mixed patterns
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = $urandom, b = $urandom;
      case ($urandom % 6)
        0: b = a;
        1: b = a ^ 32'h8000_0000;
        2: a[30:23] = 8'h00;
        3: b[30:23] = 8'hFF;
        4: begin a[30:0] = '0; b[30:0] = '0; end
        default: ;
      endcase
      apply(a, b, 2'($urandom), 1'($urandom % 4 != 0), "R10");
    end
    apply(P1, P1, 2'b00, 0, "R7");
    repeat (2) @(posedge clk);
    #(CLK_PERIOD/4);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule